// File: doc/BRIEF.md
# Double-Buffered Serial Character Receiver

This block turns a serial bit stream on `rxd` into parallel characters. A shift stage assembles each character bit by bit. When the character is complete it moves into a separate holding register, and a CPU-side consumer drains that register. The receive clock arrives as a strobe, `rx_tick`, that is synchronous to `clk`; each strobe stands for one receive clock period. In asynchronous mode the strobe runs at 1, 16 or 64 times the bit rate. A low line seen while idle starts a candidate start bit. At 16x and 64x the line is checked again half a bit later, and a character is assembled only if the line is still low. In synchronous mode every strobe carries one data bit, and characters follow one another with no start or stop bits.

The holding register is offered on a valid/ready output. `rx_valid` is the receiver-ready status. A character is consumed on any clock where `rx_valid` and `rx_ready` are both high. Back-pressure does not stall the line, because serial data cannot be held back. If a new character completes while the previous one is still unread, the new one overwrites it and the sticky `rx_overrun` flag is set. Each buffered character carries a framing-error bit. The mode inputs must be held stable while a character is in flight.

Top module: `usart_rx`

## Requirements
- R1: After reset, `rx_valid`, `rx_overrun` and `rx_frame_err` are 0.
- R2: With `clk_factor`=01 (16x), a start bit is accepted only if the line is low again 8 ticks after the tick that first saw it low. Data bits are then sampled every 16 ticks, LSB first, followed by one stop bit.
- R3: With `clk_factor`=10 or 11 (64x), the start bit is re-checked after 32 ticks, and bits are sampled every 64 ticks.
- R4: With `clk_factor`=00 (1x), the tick that sees the line low begins the character, with no re-check. Each following tick samples one bit.
- R5: At 16x or 64x, if the line is high at the start re-check, no character is produced and the receiver returns to idle.
- R6: The character length is 5 + `char_len` (5 to 8 bits). `rx_data` holds the character right-aligned, and its unused upper bits are 0.
- R7: `rx_valid` rises within two `clk` cycles of the tick that samples the last bit of a character. The new data appears on `rx_data` at the same time.
- R8: A cycle with `rx_valid` and `rx_ready` both high consumes the character, and `rx_valid` falls unless a new character loads in that same cycle. While `rx_valid` is high and nothing is consumed, `rx_data` holds steady.
- R9: A character that loads while `rx_valid` is high and no read happens in that cycle sets `rx_overrun`. The new character replaces the old one. `rx_overrun` stays set until reset.
- R10: If the line is low at the stop-bit sample, the character is still loaded, with `rx_frame_err`=1. A good stop bit gives `rx_frame_err`=0.
- R11: With `sync_mode`=1, every tick shifts in one bit, LSB first. Characters of the programmed length follow back to back from the first tick after reset, always with `rx_frame_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 1 | Serial receive line, idle high |
| rx_tick | input | 1 | One-cycle strobe per receive clock period |
| sync_mode | input | 1 | 1 = synchronous, 0 = asynchronous |
| clk_factor | input | 2 | Async ticks per bit: 00=1, 01=16, 10/11=64 |
| char_len | input | 2 | Character length minus 5 |
| rx_valid | output | 1 | Holding register full (receiver ready) |
| rx_ready | input | 1 | Consumer reads the holding register |
| rx_data | output | DATA_W | Received character, right-aligned |
| rx_frame_err | output | 1 | Stop bit of the buffered character was low |
| rx_overrun | output | 1 | Sticky: an unread character was overwritten |

## Verification
A wrong bit counter or sample point shows up on `rx_data` as shifted or corrupted bits as soon as the character reaches the holding register. That happens at most one character time after the fault. A bad start-check or stop-check decision shows up within one frame as a spurious or missing `rx_valid`, or as a wrong `rx_frame_err`. Holding-register faults, such as a lost clear, a missed overrun or data changing while held, show up on the very next consume or load cycle.

// File: rtl/usart_rx_pkg.sv
package usart_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;

  // receive ticks per bit time for a clock-factor code
  function automatic int unsigned ticks_per_bit(input logic [1:0] code);
    case (code)
      2'b00:   return 1;
      2'b01:   return 16;
      default: return 64;
    endcase
  endfunction
endpackage

// File: rtl/usart_rx_framer.sv
module usart_rx_framer #(
  parameter int DATA_W     = 8,
  parameter int MAX_FACTOR = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              rx_tick,
  input  logic              sync_mode,
  input  logic [1:0]        clk_factor,
  input  logic [1:0]        char_len,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              bad_stop
);
  import usart_rx_pkg::*;

  localparam int CNT_W   = $clog2(MAX_FACTOR) + 1;
  localparam int BIT_W   = $clog2(DATA_W);
  localparam int LEN_W   = BIT_W + 1;
  localparam int MIN_LEN = DATA_W - 3;

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  per_bit, half_bit;
  logic [LEN_W-1:0]  bitcnt;
  logic [LEN_W-1:0]  nbits;
  logic [DATA_W-1:0] sr, sr_next;
  logic              last_bit;

  always_comb begin
    per_bit  = CNT_W'(ticks_per_bit(clk_factor));
    half_bit = per_bit >> 1;
    nbits    = LEN_W'(MIN_LEN) + LEN_W'(char_len);
    sr_next  = {rxd, sr[DATA_W-1:1]};
    last_bit = (bitcnt == nbits - LEN_W'(1));
  end

  function automatic logic [DATA_W-1:0] align(input logic [DATA_W-1:0] v,
                                               input logic [LEN_W-1:0]  n);
    return v >> (LEN_W'(DATA_W) - n);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      bitcnt   <= '0;
      sr       <= '0;
      done     <= 1'b0;
      data     <= '0;
      bad_stop <= 1'b0;
    end else begin
      done <= 1'b0;
      if (rx_tick) begin
        if (sync_mode) begin
          state <= ST_IDLE;
          sr    <= sr_next;
          if (last_bit) begin
            bitcnt   <= '0;
            done     <= 1'b1;
            data     <= align(sr_next, nbits);
            bad_stop <= 1'b0;
          end else begin
            bitcnt <= bitcnt + LEN_W'(1);
          end
        end else begin
          case (state)
            ST_IDLE: begin
              if (!rxd) begin
                cnt    <= '0;
                bitcnt <= '0;
                state  <= (per_bit == CNT_W'(1)) ? ST_DATA : ST_START;
              end
            end
            ST_START: begin
              if (cnt == half_bit - CNT_W'(1)) begin
                cnt   <= '0;
                state <= rxd ? ST_IDLE : ST_DATA;
              end else begin
                cnt <= cnt + CNT_W'(1);
              end
            end
            ST_DATA: begin
              if (cnt == per_bit - CNT_W'(1)) begin
                cnt <= '0;
                sr  <= sr_next;
                if (last_bit) state <= ST_STOP;
                else          bitcnt <= bitcnt + LEN_W'(1);
              end else begin
                cnt <= cnt + CNT_W'(1);
              end
            end
            default: begin
              if (cnt == per_bit - CNT_W'(1)) begin
                cnt      <= '0;
                done     <= 1'b1;
                data     <= align(sr, nbits);
                bad_stop <= ~rxd;
                state    <= ST_IDLE;
              end else begin
                cnt <= cnt + CNT_W'(1);
              end
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/usart_rx_holdbuf.sv
module usart_rx_holdbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_bad,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_frame_err,
  output logic              overrun
);
  logic consume;
  assign consume = rd_valid && rd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid     <= 1'b0;
      rd_data      <= '0;
      rd_frame_err <= 1'b0;
      overrun      <= 1'b0;
    end else if (load) begin
      rd_valid     <= 1'b1;
      rd_data      <= load_data;
      rd_frame_err <= load_bad;
      if (rd_valid && !rd_ready) overrun <= 1'b1;
    end else if (consume) begin
      rd_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/usart_rx.sv
module usart_rx #(
  parameter int DATA_W     = 8,
  parameter int MAX_FACTOR = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              rx_tick,
  input  logic              sync_mode,
  input  logic [1:0]        clk_factor,
  input  logic [1:0]        char_len,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_frame_err,
  output logic              rx_overrun
);
  logic              char_done;
  logic [DATA_W-1:0] char_data;
  logic              char_bad;

  usart_rx_framer #(.DATA_W(DATA_W), .MAX_FACTOR(MAX_FACTOR)) u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .rxd        (rxd),
    .rx_tick    (rx_tick),
    .sync_mode  (sync_mode),
    .clk_factor (clk_factor),
    .char_len   (char_len),
    .done       (char_done),
    .data       (char_data),
    .bad_stop   (char_bad)
  );

  usart_rx_holdbuf #(.DATA_W(DATA_W)) u_hold (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (char_done),
    .load_data    (char_data),
    .load_bad     (char_bad),
    .rd_ready     (rx_ready),
    .rd_valid     (rx_valid),
    .rd_data      (rx_data),
    .rd_frame_err (rx_frame_err),
    .overrun      (rx_overrun)
  );
endmodule

// File: rtl/usart_rx_chk.sv
module usart_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_overrun
);
  assert_ready_on_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rx_valid);

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !done) |=> !rx_valid);

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !done) |=> (rx_valid && $stable(rx_data)));

  assert_overrun_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && done) |=> rx_overrun);

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |=> rx_overrun);
endmodule

bind usart_rx usart_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .done       (char_done),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .rx_data    (rx_data),
  .rx_overrun (rx_overrun)
);

// File: tb/tb_usart_rx.sv
module tb_usart_rx;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rxd = 1'b1;
  logic          rx_tick = 1'b0;
  logic          sync_mode = 1'b0;
  logic [1:0]    clk_factor = 2'b01;
  logic [1:0]    char_len = 2'b11;
  logic          rx_valid;
  logic          rx_ready = 1'b0;
  logic [DW-1:0] rx_data;
  logic          rx_frame_err;
  logic          rx_overrun;

  int errs = 0;
  int checks = 0;

  always #2 clk = ~clk;
  always @(negedge clk) rx_tick <= ~rx_tick;

  usart_rx #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_tick(rx_tick),
    .sync_mode(sync_mode), .clk_factor(clk_factor), .char_len(char_len),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_frame_err(rx_frame_err), .rx_overrun(rx_overrun)
  );

  function automatic int fac_of(input logic [1:0] c);
    return (c == 2'b00) ? 1 : (c == 2'b01) ? 16 : 64;
  endfunction

  function automatic logic [7:0] masked(input logic [7:0] d, input int len);
    return d & 8'((1 << len) - 1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold_ticks(input int n);
    repeat (2 * n) @(negedge clk);
  endtask

  task automatic send_async(input logic [7:0] d, input int len, input bit stop);
    int f;
    f = fac_of(clk_factor);
    rxd = 1'b0;
    hold_ticks(f);
    for (int i = 0; i < len; i++) begin
      rxd = d[i];
      hold_ticks(f);
    end
    rxd = stop;
    hold_ticks(f);
    rxd = 1'b1;
    hold_ticks(f + 4);
  endtask

  task automatic send_sync(input logic [7:0] d, input int len);
    for (int i = 0; i < len; i++) begin
      rxd = d[i];
      hold_ticks(1);
    end
  endtask

  task automatic read_check(input string req, input logic [7:0] d, input logic fe);
    chk({req, " valid"}, 32'(rx_valid), 32'd1);
    chk({req, " data"}, 32'(rx_data), 32'(d));
    chk({req, " frame_err"}, 32'(rx_frame_err), 32'(fe));
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    chk({req, " R8 valid cleared"}, 32'(rx_valid), 32'd0);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    report();
  end

  initial begin
    logic [7:0] d;
    int len;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk("R1 valid", 32'(rx_valid), 32'd0);
    chk("R1 overrun", 32'(rx_overrun), 32'd0);
    chk("R1 frame_err", 32'(rx_frame_err), 32'd0);
    rst_n = 1'b1;
    hold_ticks(4);

    // directed frames, one per clock factor
    clk_factor = 2'b01; char_len = 2'b11;
    send_async(8'hA5, 8, 1'b1);
    read_check("R2 16x", 8'hA5, 1'b0);
    clk_factor = 2'b10;
    send_async(8'h3C, 8, 1'b1);
    read_check("R3 64x", 8'h3C, 1'b0);
    clk_factor = 2'b00;
    send_async(8'h81, 8, 1'b1);
    read_check("R4 1x", 8'h81, 1'b0);
    clk_factor = 2'b11; char_len = 2'b00;
    send_async(8'hFF, 5, 1'b1);
    read_check("R3 code11 R6 len5", 8'h1F, 1'b0);

    // random frames, all factors and lengths
    for (int k = 0; k < 14; k++) begin
      clk_factor = 2'($urandom_range(0, 2));
      char_len   = 2'($urandom_range(0, 3));
      len = 5 + int'(char_len);
      d = 8'($urandom);
      send_async(d, len, 1'b1);
      read_check((clk_factor == 2'b00) ? "R4 R6 rand" :
                 (clk_factor == 2'b01) ? "R2 R6 rand" : "R3 R6 rand",
                 masked(d, len), 1'b0);
    end

    // false starts
    clk_factor = 2'b01; char_len = 2'b11;
    rxd = 1'b0; hold_ticks(3); rxd = 1'b1; hold_ticks(200);
    chk("R5 16x glitch", 32'(rx_valid), 32'd0);
    clk_factor = 2'b10;
    rxd = 1'b0; hold_ticks(20); rxd = 1'b1; hold_ticks(800);
    chk("R5 64x glitch", 32'(rx_valid), 32'd0);
    clk_factor = 2'b01;
    send_async(8'h5A, 8, 1'b1);
    read_check("R5 recovers", 8'h5A, 1'b0);

    // framing error
    send_async(8'hC3, 8, 1'b0);
    read_check("R10 bad stop", 8'hC3, 1'b1);
    clk_factor = 2'b00;
    send_async(8'h0F, 8, 1'b0);
    read_check("R10 bad stop 1x", 8'h0F, 1'b1);
    send_async(8'h77, 8, 1'b1);
    read_check("R10 good stop", 8'h77, 1'b0);

    // overrun
    clk_factor = 2'b01;
    chk("R9 none yet", 32'(rx_overrun), 32'd0);
    send_async(8'h11, 8, 1'b1);
    chk("R8 held unread", 32'(rx_data), 32'h11);
    send_async(8'h22, 8, 1'b1);
    chk("R9 overrun set", 32'(rx_overrun), 32'd1);
    read_check("R9 newest kept", 8'h22, 1'b0);
    send_async(8'h33, 8, 1'b1);
    read_check("R9 after", 8'h33, 1'b0);
    chk("R9 sticky", 32'(rx_overrun), 32'd1);

    // synchronous mode
    @(negedge clk);
    rst_n = 1'b0; sync_mode = 1'b1; char_len = 2'b11;
    repeat (4) @(negedge clk);
    chk("R1 overrun cleared", 32'(rx_overrun), 32'd0);
    rst_n = 1'b1;
    send_sync(8'h96, 8);
    fork
      send_sync(8'h4B, 8);
      begin
        repeat (4) @(negedge clk);
        read_check("R11 sync first", 8'h96, 1'b0);
      end
    join
    repeat (4) @(negedge clk);
    read_check("R11 sync second", 8'h4B, 1'b0);
    chk("R11 no overrun", 32'(rx_overrun), 32'd0);

    report();
  end
endmodule